// File: doc/BRIEF.md
# Converter Result Register with Byte Coherency

This block sits between a data converter and an 8-bit processor bus. Each conversion that finishes delivers a 12-bit result with a one-cycle done strobe. The block right-justifies the result to the selected resolution, stores it, sets a completion flag and, when enabled, requests an interrupt. Software reads the result as a high byte and a low byte. In the 10-bit and 12-bit resolutions, a high-byte read locks the visible result. The following low-byte read therefore always returns the same conversion as the high byte. Results that arrive while the lock is held wait in a one-entry holding register and become visible when the lock is released.

A write to the control register starts a new conversion. It also clears the flag and the overrun bit, and it drops any held result. When a write and a done strobe fall on the same clock edge, the write takes effect and the finishing result is thrown away. In single-shot operation the block accepts one result per start. In continuous operation every result is accepted, and overwriting an unread result raises an overrun bit.

Top module: `adc_result_regs`

## Requirements
- R1: After reset, `rd_data`, `conv_flag`, `overrun`, `irq` and `start_conv` are all 0.
- R2: An accepted done strobe loads the result and sets `conv_flag` on the same edge. A high-byte read places `{4'b0, result[11:8]}` on `rd_data` and a low-byte read places `result[7:0]`. In both cases `rd_data` is valid one cycle after the read strobe.
- R3: `res_mode` selects the resolution: 0 is 8-bit, 1 is 10-bit, 2 or 3 is 12-bit. Only the low 8, 10 or 12 bits of `conv_data` are kept. In 8-bit resolution a high-byte read returns 0.
- R4: In 10-bit and 12-bit resolution, a high-byte read locks the visible result. A done strobe that arrives afterwards does not change the low byte that the next low-byte read returns.
- R5: A done strobe on the same edge as a high-byte read is held back. The following low-byte read returns the older conversion.
- R6: A low-byte read releases the lock. A held result becomes visible on that same edge and sets `conv_flag`.
- R7: A control write pulses `start_conv` high for exactly one cycle and clears `conv_flag` and `overrun`. In `ctrl_wdata`, bit 0 selects continuous operation and bit 1 enables the interrupt.
- R8: When a control write and a done strobe share an edge, `conv_flag` ends at 0 and the visible result is unchanged.
- R9: `irq` is high exactly while `conv_flag` is set and the interrupt is enabled.
- R10: In single-shot operation, a done strobe after the first accepted one, and before the next control write, is ignored.
- R11: In continuous operation, a result that overwrites an unread one sets `overrun`.
- R12: In 8-bit resolution any low-byte read clears `conv_flag`. In wider resolutions only a low-byte read that follows a high-byte read clears it.
- R13: A control write releases the lock and discards any held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| res_mode | input | 2 | Resolution select (0: 8, 1: 10, 2/3: 12 bits) |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data (bit0 continuous, bit1 irq enable) |
| rd_hi | input | 1 | High result byte read strobe |
| rd_lo | input | 1 | Low result byte read strobe |
| conv_done | input | 1 | One-cycle conversion done strobe |
| conv_data | input | 12 | Converter result |
| rd_data | output | 8 | Registered read data |
| start_conv | output | 1 | One-cycle conversion start pulse |
| conv_flag | output | 1 | Conversion complete flag |
| overrun | output | 1 | Unread result overwritten |
| irq | output | 1 | Interrupt request |

## Verification
Every state change lands on the clock edge that samples its strobe. The flag, overrun and interrupt are therefore due one cycle after a done, read or write strobe, and read data is due one cycle after the read strobe. The bench drives each strobe for exactly one cycle starting at a falling edge and checks at the next falling edge, half a period after the register has loaded. The race cases put the done strobe into that same single cycle as the read or the write, so each result can be checked against one specific edge.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;
  localparam int DATA_W = 12;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RES_8  = 2'd0,
    RES_10 = 2'd1,
    RES_12 = 2'd2,
    RES_12B = 2'd3
  } res_e;

  // Right-justify a raw converter word to the selected resolution.
  function automatic logic [DATA_W-1:0] fit_result(input logic [1:0] mode,
                                                    input logic [DATA_W-1:0] raw);
    logic [DATA_W-1:0] mask;
    case (mode)
      RES_8:   mask = {DATA_W{1'b1}} >> (DATA_W - BYTE_W);
      RES_10:  mask = {DATA_W{1'b1}} >> 2;
      default: mask = {DATA_W{1'b1}};
    endcase
    return raw & mask;
  endfunction
endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_wdata,
  input  logic       conv_done,
  output logic       cont_q,
  output logic       int_en_q,
  output logic       start_q,
  output logic       done_ok
);
  logic busy_q;

  // A write on the same edge wins: the finishing result is dropped.
  assign done_ok = conv_done && busy_q && !ctrl_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cont_q   <= 1'b0;
      int_en_q <= 1'b0;
      start_q  <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      start_q <= ctrl_wr;
      if (ctrl_wr) begin
        cont_q   <= ctrl_wdata[0];
        int_en_q <= ctrl_wdata[1];
        busy_q   <= 1'b1;
      end else if (done_ok && !cont_q) begin
        busy_q <= 1'b0;
      end
    end
  end

  p_single_once_r10: assert property (@(posedge clk) disable iff (rst)
    (done_ok && !cont_q) |=> !busy_q);
  p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> busy_q);
endmodule

// File: rtl/adc_result_path.sv
module adc_result_path
  import adc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        res_mode,
  input  logic              ctrl_wr,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic              done_ok,
  input  logic [DATA_W-1:0] conv_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              new_result,
  output logic              clear_rd,
  output logic              pend_drop
);
  localparam int PAD_W = 2*BYTE_W - DATA_W;

  logic [DATA_W-1:0] vis_q, pend_q, fitted;
  logic              pend_v_q, frozen_q, hold_next;
  logic              wide, to_pend, direct, xfer;

  assign wide   = (res_mode != RES_8);
  assign fitted = fit_result(res_mode, conv_data);

  always_comb begin
    if (ctrl_wr)             hold_next = 1'b0;
    else if (rd_hi && wide)  hold_next = 1'b1;
    else if (rd_lo)          hold_next = 1'b0;
    else                     hold_next = frozen_q;
  end

  assign to_pend    = done_ok && hold_next;
  assign direct     = done_ok && !hold_next;
  assign xfer       = pend_v_q && !hold_next && !ctrl_wr && !direct;
  assign new_result = direct || xfer;
  assign pend_drop  = to_pend && pend_v_q;
  assign clear_rd   = rd_lo && (frozen_q || !wide);

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      frozen_q <= 1'b0;
      rd_data  <= '0;
    end else begin
      frozen_q <= hold_next;
      if (direct)    vis_q <= fitted;
      else if (xfer) vis_q <= pend_q;
      if (to_pend) begin
        pend_q   <= fitted;
        pend_v_q <= 1'b1;
      end else if (ctrl_wr || xfer || direct) begin
        pend_v_q <= 1'b0;
      end
      if (rd_hi)
        rd_data <= wide ? {{PAD_W{1'b0}}, vis_q[DATA_W-1:BYTE_W]} : '0;
      else if (rd_lo)
        rd_data <= vis_q[BYTE_W-1:0];
    end
  end

  p_freeze_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (frozen_q && !rd_lo && !ctrl_wr) |=> $stable(vis_q));
  p_race_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_hi && wide && done_ok) |=> $stable(vis_q));
  p_narrow_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_hi && !wide) |=> (rd_data == '0));
  p_wr_release_r13: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> !frozen_q && !pend_v_q);
endmodule

// File: rtl/adc_flag_unit.sv
module adc_flag_unit (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic cont,
  input  logic int_en,
  input  logic new_result,
  input  logic clear_rd,
  input  logic pend_drop,
  output logic flag_q,
  output logic ovr_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (ctrl_wr) begin
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (new_result)    flag_q <= 1'b1;
      else if (clear_rd) flag_q <= 1'b0;
      if (cont && ((new_result && flag_q && !clear_rd) || pend_drop))
        ovr_q <= 1'b1;
    end
  end

  assign irq = flag_q && int_en;

  p_wr_clears_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (!flag_q && !ovr_q));
  p_new_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (new_result && !ctrl_wr) |=> flag_q);
  p_ovr_cont_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $past(cont));
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        res_mode,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_wdata,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              start_conv,
  output logic              conv_flag,
  output logic              overrun,
  output logic              irq
);
  logic cont, int_en, done_ok, new_result, clear_rd, pend_drop;

  adc_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .conv_done(conv_done), .cont_q(cont), .int_en_q(int_en),
    .start_q(start_conv), .done_ok(done_ok)
  );

  adc_result_path u_path (
    .clk(clk), .rst(rst), .res_mode(res_mode), .ctrl_wr(ctrl_wr),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .done_ok(done_ok), .conv_data(conv_data),
    .rd_data(rd_data), .new_result(new_result), .clear_rd(clear_rd),
    .pend_drop(pend_drop)
  );

  adc_flag_unit u_flag (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .cont(cont), .int_en(int_en),
    .new_result(new_result), .clear_rd(clear_rd), .pend_drop(pend_drop),
    .flag_q(conv_flag), .ovr_q(overrun), .irq(irq)
  );

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> conv_flag);
endmodule

// File: tb/adc_result_regs_test.sv
module adc_result_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0, rst = 1'b1;
  logic [1:0] res_mode = 2'd2;
  logic       ctrl_wr = 1'b0, rd_hi = 1'b0, rd_lo = 1'b0, conv_done = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [11:0] conv_data = '0;
  logic [7:0] rd_data;
  logic       start_conv, conv_flag, overrun, irq;
  int errors = 0, checks = 0, cycles = 0;
  logic [7:0] b;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_regs uut (
    .clk(clk), .rst(rst), .res_mode(res_mode), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .conv_done(conv_done), .conv_data(conv_data), .rd_data(rd_data),
    .start_conv(start_conv), .conv_flag(conv_flag), .overrun(overrun), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: got %0d cycles, expected < %0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr_ctrl(input logic [7:0] d);
    ctrl_wr = 1'b1; ctrl_wdata = d; step(); ctrl_wr = 1'b0;
  endtask
  task automatic done(input logic [11:0] d);
    conv_done = 1'b1; conv_data = d; step(); conv_done = 1'b0;
  endtask
  task automatic read_hi(output logic [7:0] v);
    rd_hi = 1'b1; step(); rd_hi = 1'b0; v = rd_data;
  endtask
  task automatic read_lo(output logic [7:0] v);
    rd_lo = 1'b1; step(); rd_lo = 1'b0; v = rd_data;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 0); chk("R1 flag", conv_flag, 0);
    chk("R1 overrun", overrun, 0); chk("R1 irq", irq, 0);
    chk("R1 start", start_conv, 0);
  endtask

  task automatic t_basic();
    res_mode = 2'd2;
    wr_ctrl(8'h00); chk("R7 start pulse", start_conv, 1);
    step(); chk("R7 start one cycle", start_conv, 0);
    done(12'hABC); chk("R2 flag set", conv_flag, 1);
    read_hi(b); chk("R2 high byte", b, 8'h0A);
    chk("R12 flag kept after high", conv_flag, 1);
    read_lo(b); chk("R2 low byte", b, 8'hBC);
    chk("R12 flag cleared by low after high", conv_flag, 0);
  endtask

  task automatic t_modes();
    res_mode = 2'd1; wr_ctrl(8'h00); done(12'hFFF);
    read_hi(b); chk("R3 10-bit high", b, 8'h03);
    read_lo(b); chk("R3 10-bit low", b, 8'hFF);
    res_mode = 2'd0; wr_ctrl(8'h00); done(12'h5A7);
    read_hi(b); chk("R3 8-bit high", b, 8'h00);
    chk("R12 8-bit flag before low", conv_flag, 1);
    read_lo(b); chk("R3 8-bit low", b, 8'hA7);
    chk("R12 8-bit low clears flag", conv_flag, 0);
    res_mode = 2'd2; wr_ctrl(8'h00); done(12'h123);
    read_lo(b); chk("R12 lone low byte", b, 8'h23);
    chk("R12 lone low keeps flag", conv_flag, 1);
  endtask

  task automatic t_freeze();
    res_mode = 2'd3; wr_ctrl(8'h01); done(12'h111);
    read_hi(b); chk("R4 high", b, 8'h01);
    done(12'h222);
    read_lo(b); chk("R4 low frozen", b, 8'h11);
    chk("R6 flag after transfer", conv_flag, 1);
    chk("R11 no overrun", overrun, 0);
    read_hi(b); chk("R6 transferred high", b, 8'h02);
    read_lo(b); chk("R6 transferred low", b, 8'h22);
  endtask

  task automatic t_race_read();
    res_mode = 2'd2; wr_ctrl(8'h01); done(12'h333);
    rd_hi = 1'b1; conv_done = 1'b1; conv_data = 12'h444; step();
    rd_hi = 1'b0; conv_done = 1'b0;
    chk("R5 high same edge", rd_data, 8'h03);
    read_lo(b); chk("R5 low older conversion", b, 8'h33);
    read_hi(b); chk("R5 newer high", b, 8'h04);
    read_lo(b); chk("R5 newer low", b, 8'h44);
  endtask

  task automatic t_wr_release();
    wr_ctrl(8'h01); done(12'h555);
    read_hi(b); done(12'h666);
    wr_ctrl(8'h01); chk("R13 flag cleared", conv_flag, 0);
    read_lo(b); chk("R13 pending discarded", b, 8'h55);
    chk("R13 flag stays clear", conv_flag, 0);
  endtask

  task automatic t_race_write();
    wr_ctrl(8'h00); done(12'h789);
    ctrl_wr = 1'b1; ctrl_wdata = 8'h00; conv_done = 1'b1; conv_data = 12'h7AA;
    step(); ctrl_wr = 1'b0; conv_done = 1'b0;
    chk("R8 flag clear", conv_flag, 0);
    read_hi(b); chk("R8 high unchanged", b, 8'h07);
    read_lo(b); chk("R8 low unchanged", b, 8'h89);
  endtask

  task automatic t_irq_single();
    wr_ctrl(8'h02); chk("R9 irq idle", irq, 0);
    done(12'h010); chk("R9 irq raised", irq, 1);
    read_hi(b); read_lo(b); chk("R9 irq dropped", irq, 0);
    done(12'h999); chk("R10 ignored flag", conv_flag, 0);
    read_hi(b); chk("R10 high kept", b, 8'h00);
    read_lo(b); chk("R10 low kept", b, 8'h10);
  endtask

  task automatic t_overrun();
    wr_ctrl(8'h01); done(12'hAAA); chk("R11 first no overrun", overrun, 0);
    done(12'hBBB); chk("R11 overrun set", overrun, 1);
    chk("R11 flag set", conv_flag, 1);
    read_hi(b); chk("R11 newest high", b, 8'h0B);
    read_lo(b); chk("R11 newest low", b, 8'hBB);
    wr_ctrl(8'h00); chk("R7 overrun cleared", overrun, 0);
  endtask

  initial begin
    step(); step(); rst = 1'b0; step();
    t_reset(); t_basic(); t_modes(); t_freeze(); t_race_read();
    t_wr_release(); t_race_write(); t_irq_single(); t_overrun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule